// File: doc/BRIEF.md
# Dual-Read Register File

A general-purpose register array holding thirty-two 32-bit entries, with one write port and two independent read ports. Each read port takes a 5-bit selector and presents the selected entry on its data output through purely combinational logic, so an operand is available in the same cycle its selector is applied. Entry 0 is a constant zero: it reads as zero on both ports and silently drops any write aimed at it.

The write port is sampled on the falling clock edge, and only when its enable is high. The write data and selector are set up in the first half of a clock period and commit at mid-period. A read of the same entry therefore shows the new value in the second half of that same period, so a producer and a consumer can share one cycle without a forwarding path. An active-low asynchronous reset clears entries 1 through 31.

Top module: `dual_read_regfile`

## Requirements
- R1: Each of entries 1 to 31 stores a full 32-bit value written to it and returns that value unchanged when later selected on a read port.
- R2: Selector value 0 on either read port always yields 0x00000000, even after a write with enable high and write selector 0.
- R3: The two read ports are independent: port A shows the entry named by rsel_a_i and port B the entry named by rsel_b_i, including when both name different or identical entries at the same time.
- R4: Reads have no clock latency: a change of a read selector changes the matching data output with no clock edge in between.
- R5: With wen_i low, a falling clock edge changes no entry, whatever wsel_i and wdata_i hold.
- R6: A write with wen_i high commits on the falling clock edge. Before that edge a read of the target shows the old value; after it, and before the next rising edge, the read shows the new value.
- R7: While rst_ni is low, entries 1 to 31 are cleared to zero at once, without waiting for a clock edge, and all reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes commit on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_i | input | 1 | Write enable |
| wsel_i | input | 5 | Entry selected for writing |
| wdata_i | input | 32 | Value to write |
| rsel_a_i | input | 5 | Entry selected on read port A |
| rsel_b_i | input | 5 | Entry selected on read port B |
| rdata_a_o | output | 32 | Read port A data |
| rdata_b_o | output | 32 | Read port B data |

## Verification
A corrupted or stale entry stays hidden until it is selected. It then shows on the read data in the same half-cycle, because no register sits between the storage and the outputs. The bench therefore reads back every entry it writes in the second half of the writing cycle, and reads a second entry on the other port in that cycle. A write that lands on the wrong edge, the wrong entry, or entry 0 differs from the model at the very next sample. A lost or spurious write shows up the first time the affected entry is read again.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ENTRIES = 32;
  localparam int unsigned RF_WIDTH   = 32;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES,
  localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
  input  logic               wen_i,
  input  logic [SEL_W-1:0]   wsel_i,
  output logic [ENTRIES-1:0] wen_vec_o
);
  // entry 0 never receives an enable
  assign wen_vec_o[0] = 1'b0;
  for (genvar k = 1; k < ENTRIES; k++) begin : g_dec
    assign wen_vec_o[k] = wen_i && (wsel_i == SEL_W'(k));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES,
  parameter int unsigned WIDTH   = rf_pkg::RF_WIDTH
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ENTRIES-1:0]             wen_vec_i,
  input  logic [WIDTH-1:0]               wdata_i,
  output logic [ENTRIES-1:0][WIDTH-1:0]  entries_o
);
  assign entries_o[0] = '0;

  for (genvar k = 1; k < ENTRIES; k++) begin : g_ent
    logic [WIDTH-1:0] q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q <= '0;
      else if (wen_vec_i[k]) q <= wdata_i;
    end
    assign entries_o[k] = q;

    AST_WRITE_LANDS: assert property (@(negedge clk_i) disable iff (!rst_ni)
      wen_vec_i[k] |=> (q == $past(wdata_i))) else $error("write lost"); // R6
  end

  AST_ONE_TARGET: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0(wen_vec_i)) else $error("multiple write targets"); // R1

  AST_IDLE_HOLDS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (wen_vec_i == '0) |=> $stable(entries_o)) else $error("idle change"); // R5
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES,
  parameter int unsigned WIDTH   = rf_pkg::RF_WIDTH,
  localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] entries_i,
  input  logic [SEL_W-1:0]              rsel_i,
  output logic [WIDTH-1:0]              rdata_o
);
  assign rdata_o = entries_i[rsel_i];
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int unsigned ENTRIES = rf_pkg::RF_ENTRIES,
  parameter int unsigned WIDTH   = rf_pkg::RF_WIDTH,
  localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wen_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [SEL_W-1:0] rsel_a_i,
  input  logic [SEL_W-1:0] rsel_b_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [ENTRIES-1:0]            wen_vec;
  logic [ENTRIES-1:0][WIDTH-1:0] entries;

  rf_wr_decode #(.ENTRIES(ENTRIES)) u_dec (
    .wen_i     (wen_i),
    .wsel_i    (wsel_i),
    .wen_vec_o (wen_vec)
  );

  rf_storage #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wen_vec_i (wen_vec),
    .wdata_i   (wdata_i),
    .entries_o (entries)
  );

  rf_rd_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rd_a (
    .entries_i (entries),
    .rsel_i    (rsel_a_i),
    .rdata_o   (rdata_a_o)
  );

  rf_rd_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rd_b (
    .entries_i (entries),
    .rsel_i    (rsel_b_i),
    .rdata_o   (rdata_b_o)
  );

  AST_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_a_i == '0) |-> (rdata_a_o == '0)) else $error("port A zero"); // R2
  AST_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_b_i == '0) |-> (rdata_b_o == '0)) else $error("port B zero"); // R2
  AST_SAME_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_a_i == rsel_b_i) |-> (rdata_a_o == rdata_b_o)) else $error("ports differ"); // R3
endmodule

// File: tb/dual_read_regfile_tb_top.sv
`timescale 1ns/100ps
module dual_read_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wen_i = 1'b0;
  logic [4:0]  wsel_i = '0;
  logic [31:0] wdata_i = '0;
  logic [4:0]  rsel_a_i = '0;
  logic [4:0]  rsel_b_i = '0;
  logic [31:0] rdata_a_o, rdata_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] model [32];
  logic [4:0]  q_sa[$], q_sb[$];
  logic [31:0] q_ea[$], q_eb[$];
  string       q_tag[$];

  always #2 clk_i = ~clk_i; // 250 MHz

  dual_read_regfile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wen_i(wen_i), .wsel_i(wsel_i),
    .wdata_i(wdata_i), .rsel_a_i(rsel_a_i), .rsel_b_i(rsel_b_i),
    .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: one cycle of stimulus; expected result pushed for the monitor
  task automatic step(bit we, logic [4:0] ws, logic [31:0] wd,
                      logic [4:0] sa, logic [4:0] sb, string tag);
    @(posedge clk_i);
    #0.5;
    wen_i = we; wsel_i = ws; wdata_i = wd; rsel_a_i = sa; rsel_b_i = sb;
    if (we && ws == sa) begin
      #1; // still before the falling edge: old value expected (R6)
      chk("R6 pre-edge", rdata_a_o, model[sa]);
    end
    if (we && ws != 5'd0) model[ws] = wd;
    q_sa.push_back(sa); q_sb.push_back(sb);
    q_ea.push_back(model[sa]); q_eb.push_back(model[sb]);
    q_tag.push_back(tag);
  endtask

  // monitor: samples after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (q_ea.size() > 0) begin
        string t;
        logic [31:0] ea, eb;
        logic [4:0] sa, sb;
        t = q_tag.pop_front(); ea = q_ea.pop_front(); eb = q_eb.pop_front();
        sa = q_sa.pop_front(); sb = q_sb.pop_front();
        chk($sformatf("%s port A sel %0d", t, sa), rdata_a_o, ea);
        chk($sformatf("%s port B sel %0d", t, sb), rdata_b_o, eb);
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    // R7: reset state, no clock needed for reads
    #1;
    for (int i = 0; i < 32; i++) begin
      rsel_a_i = 5'(i); rsel_b_i = 5'(31 - i);
      #0.1;
      chk("R7 reset A", rdata_a_o, 32'h0);
      chk("R7 reset B", rdata_b_o, 32'h0);
    end
    repeat (2) @(posedge clk_i);
    #0.5 rst_ni = 1'b1;

    // R1 R3 R6: fill all entries, read back same cycle on A, previous on B
    for (int i = 1; i < 32; i++)
      step(1'b1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 5'(i), 5'(i - 1), "R1");
    // R3: both ports on the same entry, then crossed
    step(1'b0, 5'd0, 32'h0, 5'd7, 5'd7, "R3");
    step(1'b0, 5'd0, 32'h0, 5'd31, 5'd1, "R3");
    // R2: write at entry 0 has no effect
    step(1'b1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0, "R2");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd9, "R2");
    // R5: enable low leaves target intact
    step(1'b0, 5'd5, 32'hDEADBEEF, 5'd5, 5'd5, "R5");
    step(1'b0, 5'd31, 32'h12345678, 5'd31, 5'd5, "R5");
    // R6: all-ones and all-zeros through the same-cycle path
    step(1'b1, 5'd12, 32'hFFFFFFFF, 5'd12, 5'd12, "R6");
    step(1'b1, 5'd12, 32'h00000000, 5'd12, 5'd11, "R6");

    // R4: selector change with no clock edge
    @(posedge clk_i);
    #0.5 wen_i = 1'b0; rsel_a_i = 5'd3;
    #0.3 chk("R4 comb A", rdata_a_o, model[3]);
    rsel_a_i = 5'd30;
    #0.3 chk("R4 comb A", rdata_a_o, model[30]);
    rsel_b_i = 5'd17;
    #0.3 chk("R4 comb B", rdata_b_o, model[17]);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [4:0] ws, sa, sb;
      bit we;
      we = ($urandom % 4) != 0;
      ws = 5'($urandom); sa = ($urandom % 3 == 0) ? ws : 5'($urandom);
      sb = 5'($urandom);
      step(we, ws, $urandom, sa, sb, we ? "R6 mix" : "R5 mix");
    end

    // R7: asynchronous reset in the middle of a cycle
    @(posedge clk_i);
    #0.5 wen_i = 1'b0; rsel_a_i = 5'd9; rsel_b_i = 5'd20;
    #0.3 rst_ni = 1'b0;
    #0.2;
    chk("R7 async A", rdata_a_o, 32'h0);
    chk("R7 async B", rdata_b_o, 32'h0);
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(posedge clk_i);
    #0.5 rst_ni = 1'b1;
    for (int i = 1; i < 32; i += 2)
      step(1'b0, 5'd0, 32'h0, 5'(i), 5'(i - 1), "R7 after");
    step(1'b1, 5'd4, 32'h0BADF00D, 5'd4, 5'd0, "R1 after");

    @(posedge clk_i);
    @(posedge clk_i);
    finish_run();
  end
endmodule